// File: doc/BRIEF.md
# SPI Slave Front End with Deferred Write Commit

This block is the serial front end of a small register or memory device. An SPI master drives it in mode 0 (clock idle low, data sampled on the rising edge) with an active-low select. The block decodes a one-byte instruction, collects an 8-bit address, and then either streams read data back from the device, or hands each complete incoming data byte to the device's staging latch. The staged bytes are made permanent only through a single commit strobe. That strobe fires when the select line is released after a complete write that was enabled beforehand.

All serial inputs pass through synchronizers into the system clock domain, and the bit engine runs on the detected edges. The device reports its internal programming cycle on a busy input. The block rejects writes while that input is high, and it holds its standby indication low until the cycle ends, even if the master has already deselected. After reset the interface stays locked until it sees a high-to-low transition of the select line.

Top module: `spi_dwc_slave`

## Requirements
- R1: On each rising SCK edge, the block shifts in the serial input MSB first. The first byte of a transaction is the instruction: 0x03 reads, 0x02 writes and 0x06 sets the write-enable latch. Any other code makes the block ignore the rest of the transaction. A read or write instruction is followed by an 8-bit address byte.
- R2: The serial output changes only in the system clock cycle after a detected falling SCK edge. Read data goes out MSB first, and its first bit is valid before the first rising SCK edge of the data phase.
- R3: The output enable is low whenever the synchronized select line is high, so the pin is high-impedance.
- R4: After reset, the block ignores all traffic until it detects a high-to-low transition of the select line. While locked, the output enable, the stage strobe and the commit strobe stay low.
- R5: The commit strobe pulses for one cycle just after a detected select rise. It pulses only when four conditions hold: the write-enable latch was set, the instruction was 0x02, the address was complete, and at least one full data byte arrived.
- R6: Only complete data bytes are staged, one stage pulse per byte. Bits of a partial byte at the select rise are discarded.
- R7: The address advances by one after each data byte, for both reads and writes, and wraps from 0xFF to 0x00.
- R8: A commit clears the write-enable latch, so a later write without a new 0x06 is not committed.
- R9: While the busy input is high, a write is rejected, either when its instruction is decoded or at the select rise, and no commit is issued.
- R10: The standby output is high only when the select line is high and busy is low. A programming cycle that is running keeps standby low after deselection.
- R11: Every select rise clears the bit counter and the instruction state, so a transaction cut off mid-byte does not disturb the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| standby | output | 1 | Deselected and no programming cycle running |
| reg_addr | output | 8 | Current device address for reads |
| rd_data | input | 8 | Device data at reg_addr |
| stage_valid | output | 1 | One-cycle strobe: a full write byte is staged |
| stage_addr | output | 8 | Address of the staged byte |
| stage_data | output | 8 | Value of the staged byte |
| wr_commit | output | 1 | One-cycle strobe: start the programming cycle |
| prog_busy | input | 1 | Device programming cycle in progress |

## Verification
Directed write transactions cover five cases: a write with enable, one without, one that stops after the address, one that ends in a partial byte, and one sent while busy. Each case is judged by how many commit and stage strobes it produces, which separates the enable, completeness and busy conditions from one another. Reads across the 0xFF boundary and after a transaction cut off mid-instruction separate address wrapping from counter clearing. Traffic sent before the first select fall shows whether the lock works. A seeded random mix of enabled writes and multi-byte reads is then compared against a memory image that the bench keeps.

// File: rtl/spi_dwc_pkg.sv
package spi_dwc_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;
    localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_RDATA,
        PH_WDATA,
        PH_SKIP
    } phase_e;

    // Edge events of the serial pins in the system clock domain
    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_rise;
        logic cs_fall;
        logic sel;
        logic mosi;
    } spi_evt_t;

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur,
                                                   input logic bit_in);
        return {cur[BYTE_W-2:0], bit_in};
    endfunction

endpackage

// File: rtl/spi_dwc_sync.sv
module spi_dwc_sync
    import spi_dwc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck,
    input  logic     cs_n,
    input  logic     mosi,
    output spi_evt_t evt
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sck_d, cs_d;

    assign raw = {mosi, cs_n, sck};

    genvar g;
    generate
        for (g = 0; g < NSIG; g++) begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    // Select chain resets low: a select held low through reset gives no fall
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b0;
        end else begin
            sck_d <= synced[0];
            cs_d  <= synced[1];
        end
    end

    always_comb begin
        evt.sck_rise = synced[0] & ~sck_d;
        evt.sck_fall = ~synced[0] & sck_d;
        evt.cs_rise  = synced[1] & ~cs_d;
        evt.cs_fall  = ~synced[1] & cs_d;
        evt.sel      = ~synced[1];
        evt.mosi     = synced[2];
    end

endmodule

// File: rtl/spi_dwc_ctrl.sv
module spi_dwc_ctrl
    import spi_dwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  spi_evt_t          evt,
    input  logic              prog_busy,
    output logic              armed,
    output logic              wel,
    output logic [CNT_W-1:0]  bcnt,
    output logic              rd_phase,
    output logic              byte_start,
    output logic [ADDR_W-1:0] addr,
    output logic              stage_valid,
    output logic [ADDR_W-1:0] stage_addr,
    output logic [BYTE_W-1:0] stage_data,
    output logic              wr_commit
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    phase_e            phase;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] byte_w;
    logic              rd_mode;
    logic              wr_ok;

    assign byte_w     = shift_in(sh, evt.mosi);
    assign rd_phase   = (phase == PH_RDATA);
    assign byte_start = (bcnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed       <= 1'b0;
            wel         <= 1'b0;
            phase       <= PH_CMD;
            bcnt        <= '0;
            sh          <= '0;
            rd_mode     <= 1'b0;
            wr_ok       <= 1'b0;
            addr        <= '0;
            stage_valid <= 1'b0;
            stage_addr  <= '0;
            stage_data  <= '0;
            wr_commit   <= 1'b0;
        end else begin
            stage_valid <= 1'b0;
            wr_commit   <= 1'b0;
            if (evt.cs_fall) begin
                armed <= 1'b1;
                bcnt  <= '0;
                phase <= PH_CMD;
            end
            if (evt.cs_rise) begin
                if (armed && phase == PH_WDATA && wr_ok && !prog_busy) begin
                    wr_commit <= 1'b1;
                    wel       <= 1'b0;
                end
                phase <= PH_CMD;
                bcnt  <= '0;
                wr_ok <= 1'b0;
            end else if (armed && evt.sel && evt.sck_rise) begin
                bcnt <= bcnt + 1'b1;
                sh   <= byte_w;
                if (bcnt == LAST_BIT) begin
                    unique case (phase)
                        PH_CMD: begin
                            if (byte_w == OP_WREN) begin
                                wel   <= 1'b1;
                                phase <= PH_SKIP;
                            end else if (byte_w == OP_READ) begin
                                rd_mode <= 1'b1;
                                phase   <= PH_ADDR;
                            end else if (byte_w == OP_WRITE && wel && !prog_busy) begin
                                rd_mode <= 1'b0;
                                phase   <= PH_ADDR;
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        PH_ADDR: begin
                            addr  <= byte_w;
                            phase <= rd_mode ? PH_RDATA : PH_WDATA;
                        end
                        PH_WDATA: begin
                            stage_valid <= 1'b1;
                            stage_addr  <= addr;
                            stage_data  <= byte_w;
                            addr        <= addr + 1'b1;
                            wr_ok       <= 1'b1;
                        end
                        PH_RDATA: addr <= addr + 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/spi_dwc_tx.sv
module spi_dwc_tx
    import spi_dwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  spi_evt_t          evt,
    input  logic              armed,
    input  logic              rd_phase,
    input  logic              byte_start,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              miso,
    output logic              miso_oe
);
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            miso <= 1'b0;
            sh   <= '0;
        end else if (armed && evt.sel && evt.sck_fall && rd_phase) begin
            if (byte_start) begin
                miso <= rd_data[BYTE_W-1];
                sh   <= {rd_data[BYTE_W-2:0], 1'b0};
            end else begin
                miso <= sh[BYTE_W-1];
                sh   <= {sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign miso_oe = armed & evt.sel;

endmodule

// File: rtl/spi_dwc_slave.sv
module spi_dwc_slave
    import spi_dwc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              standby,
    output logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              stage_valid,
    output logic [ADDR_W-1:0] stage_addr,
    output logic [BYTE_W-1:0] stage_data,
    output logic              wr_commit,
    input  logic              prog_busy
);
    spi_evt_t         evt;
    logic             armed, wel, rd_phase, byte_start;
    logic [CNT_W-1:0] bcnt;
    logic             sck_fall, cs_rise;

    assign sck_fall = evt.sck_fall;
    assign cs_rise  = evt.cs_rise;

    spi_dwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .sck  (spi_sck),
        .cs_n (spi_cs_n),
        .mosi (spi_mosi),
        .evt  (evt)
    );

    spi_dwc_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .prog_busy   (prog_busy),
        .armed       (armed),
        .wel         (wel),
        .bcnt        (bcnt),
        .rd_phase    (rd_phase),
        .byte_start  (byte_start),
        .addr        (reg_addr),
        .stage_valid (stage_valid),
        .stage_addr  (stage_addr),
        .stage_data  (stage_data),
        .wr_commit   (wr_commit)
    );

    spi_dwc_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .armed      (armed),
        .rd_phase   (rd_phase),
        .byte_start (byte_start),
        .rd_data    (rd_data),
        .miso       (spi_miso),
        .miso_oe    (spi_miso_oe)
    );

    assign standby = ~evt.sel & ~prog_busy;

endmodule

// File: rtl/spi_dwc_checker.sv
module spi_dwc_checker (
    input logic       clk,
    input logic       rst,
    input logic       spi_miso,
    input logic       spi_miso_oe,
    input logic       stage_valid,
    input logic       wr_commit,
    input logic       prog_busy,
    input logic       sck_fall,
    input logic       cs_rise,
    input logic       armed,
    input logic       wel,
    input logic [2:0] bcnt
);
    a_r2_miso_after_fall: assert property (@(posedge clk) disable iff (rst)
        (spi_miso != $past(spi_miso)) |-> $past(sck_fall));

    a_r4_locked_quiet: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (!spi_miso_oe && !stage_valid && !wr_commit));

    a_r5_commit_on_cs_rise: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(cs_rise));

    a_r9_commit_not_busy: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> !$past(prog_busy));

    a_r8_commit_clears_wel: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> !wel);

    a_r6_stage_single: assert property (@(posedge clk) disable iff (rst)
        stage_valid |=> !stage_valid);

    a_r11_cs_rise_clears: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> (bcnt == 3'd0));

endmodule

bind spi_dwc_slave spi_dwc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .stage_valid (stage_valid),
    .wr_commit   (wr_commit),
    .prog_busy   (prog_busy),
    .sck_fall    (sck_fall),
    .cs_rise     (cs_rise),
    .armed       (armed),
    .wel         (wel),
    .bcnt        (bcnt)
);

// File: tb/spi_dwc_slave_bench.sv
module spi_dwc_slave_bench;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, busy = 1'b0;
    logic       miso, oe, standby, stage_valid, wr_commit;
    logic [7:0] reg_addr, stage_addr, stage_data, rd_data;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] pend_a [16];
    logic [7:0] pend_d [16];
    int pend_n, n_commit, n_stage, busy_cnt, busy_len;
    int total, bad, glitch;
    bit exp_wel;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    assign rd_data = mem[reg_addr];

    spi_dwc_slave u_spi_dwc_slave (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(oe), .standby(standby), .reg_addr(reg_addr),
        .rd_data(rd_data), .stage_valid(stage_valid), .stage_addr(stage_addr),
        .stage_data(stage_data), .wr_commit(wr_commit), .prog_busy(busy)
    );

    // Device model: staging latch, commit, programming time
    always @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            busy_cnt <= 0;
        end else begin
            if (stage_valid) begin
                if (pend_n < 16) begin
                    pend_a[pend_n] = stage_addr;
                    pend_d[pend_n] = stage_data;
                    pend_n = pend_n + 1;
                end
                n_stage = n_stage + 1;
            end
            if (wr_commit) begin
                for (int i = 0; i < pend_n; i++) mem[pend_a[i]] = pend_d[i];
                n_commit = n_commit + 1;
                busy <= 1'b1;
                busy_cnt <= busy_len;
            end else if (busy_cnt > 1) begin
                busy_cnt <= busy_cnt - 1;
            end else begin
                busy <= 1'b0;
                busy_cnt <= 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_lo();
        @(negedge clk);
        cs_n = 1'b0;
        pend_n = 0;
        hp();
    endtask

    task automatic cs_hi();
        hp();
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] b, input int nb, output logic [7:0] r);
        logic m0;
        r = '0;
        for (int i = 0; i < nb; i++) begin
            mosi = b[7-i];
            hp();
            r = {r[6:0], miso};
            m0 = miso;
            sck = 1'b1;
            hp();
            if (miso !== m0) glitch++;
            sck = 1'b0;
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic wren();
        logic [7:0] r;
        cs_lo(); xbits(8'h06, 8, r); cs_hi();
        exp_wel = 1'b1;
    endtask

    // Write n full bytes from wbuf plus 'extra' stray bits; returns expected commit
    task automatic wr(input logic [7:0] a, input int n, input int extra, output bit exp_c);
        logic [7:0] r;
        bit b0;
        b0 = busy;
        cs_lo();
        xbits(8'h02, 8, r);
        xbits(a, 8, r);
        for (int i = 0; i < n; i++) xbits(wbuf[i], 8, r);
        if (extra > 0) xbits(8'hA7, extra, r);
        cs_hi();
        exp_c = exp_wel && !b0 && !busy_before_rise && (n > 0);
        if (exp_c) begin
            exp_wel = 1'b0;
            for (int i = 0; i < n; i++) exp_mem[8'(a + i)] = wbuf[i];
        end
    endtask
    bit busy_before_rise = 1'b0;

    task automatic rd(input logic [7:0] a, input int n);
        logic [7:0] r;
        cs_lo();
        xbits(8'h03, 8, r);
        xbits(a, 8, r);
        for (int i = 0; i < n; i++) begin
            xbits(8'h00, 8, r);
            rbuf[i] = r;
        end
        cs_hi();
    endtask

    function automatic bit rd_match(input logic [7:0] a, input int n);
        for (int i = 0; i < n; i++)
            if (rbuf[i] !== exp_mem[8'(a + i)]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_up();
    end

    initial begin
        int c0, s0, oe_seen;
        bit ec;
        logic [7:0] r, a;
        int n;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
        pend_n = 0; n_commit = 0; n_stage = 0; busy_len = 20;
        total = 0; bad = 0; glitch = 0; exp_wel = 1'b0;

        // Select held low through reset: the interface must stay locked
        cs_n = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk(oe == 1'b0 && wr_commit == 1'b0, "R4 reset state", oe, 0);
        oe_seen = 0;
        for (int i = 0; i < 16; i++) begin
            mosi = (i % 8 == 6) || (i % 8 == 7);
            hp(); if (oe) oe_seen++;
            sck = 1'b1; hp(); if (oe) oe_seen++;
            sck = 1'b0;
        end
        chk(oe_seen == 0 && n_stage == 0, "R4 locked before select fall", oe_seen, 0);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(standby == 1'b1, "R10 standby idle", standby, 1);
        chk(oe == 1'b0, "R3 deselected high-Z", oe, 0);

        // Enabled two-byte write
        c0 = n_commit; s0 = n_stage;
        wren();
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
        wr(8'h10, 2, 0, ec);
        chk(n_commit - c0 == 1, "R5 enabled write commits", n_commit - c0, 1);
        chk(n_stage - s0 == 2, "R6 two bytes staged", n_stage - s0, 2);
        wait_idle();
        rd(8'h10, 2);
        chk(rd_match(8'h10, 2), "R1 R7 readback", {rbuf[0], rbuf[1]}, {exp_mem[8'h10], exp_mem[8'h11]});

        // No new enable after commit
        c0 = n_commit;
        wbuf[0] = 8'h77;
        wr(8'h12, 1, 0, ec);
        chk(n_commit - c0 == 0, "R8 latch cleared by commit", n_commit - c0, 0);

        // Partial trailing byte
        wait_idle();
        c0 = n_commit; s0 = n_stage;
        wren();
        wbuf[0] = 8'h5A;
        wr(8'h20, 1, 5, ec);
        chk(n_commit - c0 == 1 && n_stage - s0 == 1, "R6 partial byte dropped", n_stage - s0, 1);
        wait_idle();
        rd(8'h20, 2);
        chk(rd_match(8'h20, 2), "R6 neighbour untouched", {rbuf[0], rbuf[1]}, {exp_mem[8'h20], exp_mem[8'h21]});

        // Address only, no data byte
        c0 = n_commit;
        wren();
        wr(8'h30, 0, 3, ec);
        chk(n_commit - c0 == 0, "R5 no full data byte", n_commit - c0, 0);

        // Broken transaction then a clean read
        cs_lo(); xbits(8'h00, 4, r); cs_hi();
        rd(8'h10, 1);
        chk(rbuf[0] === exp_mem[8'h10], "R11 recovery after cut", rbuf[0], exp_mem[8'h10]);

        // Unknown opcode ignored
        s0 = n_stage;
        cs_lo(); xbits(8'h55, 8, r); xbits(8'h40, 8, r); xbits(8'hEE, 8, r); cs_hi();
        chk(n_stage == s0, "R1 unknown opcode ignored", n_stage - s0, 0);

        // Wrap across the top address
        wren();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        wr(8'hFF, 2, 0, ec);
        wait_idle();
        rd(8'hFF, 2);
        chk(rd_match(8'hFF, 2) && exp_mem[0] == 8'h22, "R7 address wrap", {rbuf[0], rbuf[1]}, 16'h1122);

        // Busy: standby held, new write rejected
        busy_len = 3000;
        wren();
        wbuf[0] = 8'h66;
        wr(8'h40, 1, 0, ec);
        chk(standby == 1'b0 && busy, "R10 standby held while busy", standby, 0);
        c0 = n_commit;
        wren();
        wbuf[0] = 8'h99;
        wr(8'h41, 1, 0, ec);
        chk(n_commit - c0 == 0, "R9 write rejected while busy", n_commit - c0, 0);
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(standby == 1'b1, "R10 standby after cycle", standby, 1);
        busy_len = 20;
        exp_wel = 1'b1;

        // Random mix
        for (int t = 0; t < 24; t++) begin
            wait_idle();
            a = 8'($urandom);
            n = 1 + int'($urandom % 4);
            if ($urandom % 2) begin
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
                c0 = n_commit;
                wren();
                wr(a, n, int'($urandom % 3), ec);
                chk(n_commit - c0 == int'(ec), "R5 random write", n_commit - c0, int'(ec));
            end else begin
                rd(a, n);
                chk(rd_match(a, n), "R7 random read", rbuf[0], exp_mem[a]);
            end
        end

        chk(glitch == 0, "R2 output steady while clock high", glitch, 0);
        chk(oe == 1'b0, "R3 high-Z at end", oe, 0);
        finish_up();
    end

endmodule